// File: doc/BRIEF.md
# Three-Dimensional Transfer Address Sequencer

This block turns one transfer descriptor into the stream of byte addresses that a DMA data path needs. A transfer is a cube of bytes. Its innermost dimension is a run of contiguous bytes called an array. A frame is a group of arrays, and the whole transfer is a group of frames. Source and destination each have their own start address. Each also has a signed step between array starts (the B step) and a signed step used at frame boundaries (the C step).

A trigger moves one slice of the transfer. In array-sync mode the slice is a single array. In frame-sync mode the slice is every remaining array of the current frame. While the slice runs, the block issues one source/destination address pair per accepted beat on a valid/ready stream. When the slice ends it pulses a done flag. In that same cycle it presents a written-back descriptor: the updated start addresses and counts that the next trigger should use. The owner of the descriptor storage copies them back. An end-of-transfer flag accompanies the done pulse once no frames remain.

The address stream obeys standard back-pressure rules. While `addr_valid_o` is high and `addr_ready_i` is low, the pair and its last-flag stay frozen. A beat is consumed only on a cycle where both are high. There is no buffering: the sequencer simply waits.

Top module: `dma3d_addr_gen`

## Requirements
- R1: After reset the block is idle: `busy_o`, `addr_valid_o`, `done_o` and `eot_o` are all low.
- R2: A high `trig_i` is accepted only while idle. The descriptor inputs are captured in that cycle. A trigger arriving while a slice is in progress or finishing is ignored and never starts a second slice.
- R3: Within an array, both source and destination addresses start at the array start and rise by one per beat, for array-length beats.
- R4: Each array after the first in a slice starts exactly the sign-extended 16-bit B step (source and destination separately) after the previous array's start.
- R5: When `cfg_ab_sync_i` is 0 (array sync) and more than one array remains in the frame, a trigger moves one array. The written-back array count drops by one, the frame count is unchanged, and each written-back address is the array start plus its B step.
- R6: When `cfg_ab_sync_i` is 0 and exactly one array remains in the frame, a trigger moves that array. The written-back array count takes the reload value, the frame count drops by one, and each written-back address is that array's start plus its C step.
- R7: When `cfg_ab_sync_i` is 1 (frame sync), a trigger moves all remaining arrays of the frame. The written-back array count is unchanged, the frame count drops by one, and each written-back address is the frame's start plus its C step.
- R8: While `addr_valid_o` is high and `addr_ready_i` is low, the valid, both addresses and `addr_last_o` hold their values into the next cycle.
- R9: `addr_last_o` is high only on the final pair of a slice. `done_o` is a one-cycle pulse in the cycle after that pair is accepted, never together with `addr_valid_o`. The `wb_*` outputs are meaningful in the done cycle.
- R10: `eot_o` is high only together with `done_o`, and exactly when the written-back frame count is zero.
- R11: If the array length, array count or frame count is zero at the trigger, no address is issued. `done_o` and `eot_o` pulse in the cycle after the trigger, the written-back frame count is zero, and the addresses and array count are written back unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| trig_i | input | 1 | Start one slice (taken only when idle) |
| cfg_src_i | input | AW | Source start address of the next array |
| cfg_dst_i | input | AW | Destination start address of the next array |
| cfg_acnt_i | input | CW | Bytes per array |
| cfg_bcnt_i | input | CW | Arrays left in the current frame |
| cfg_ccnt_i | input | CW | Frames left, current one included |
| cfg_bcnt_rld_i | input | CW | Array count loaded at each new frame |
| cfg_src_bidx_i | input | IW | Signed source step between arrays |
| cfg_dst_bidx_i | input | IW | Signed destination step between arrays |
| cfg_src_cidx_i | input | IW | Signed source step at a frame boundary |
| cfg_dst_cidx_i | input | IW | Signed destination step at a frame boundary |
| cfg_ab_sync_i | input | 1 | 0 = array sync, 1 = frame sync |
| busy_o | output | 1 | High from accepted trigger through done cycle |
| addr_valid_o | output | 1 | Address pair valid |
| addr_ready_i | input | 1 | Consumer accepts the pair |
| addr_src_o | output | AW | Source byte address |
| addr_dst_o | output | AW | Destination byte address |
| addr_last_o | output | 1 | Final pair of the slice |
| done_o | output | 1 | Slice finished; write-back valid |
| eot_o | output | 1 | Whole transfer finished |
| wb_src_o | output | AW | Source address to store back |
| wb_dst_o | output | AW | Destination address to store back |
| wb_bcnt_o | output | CW | Array count to store back |
| wb_ccnt_o | output | CW | Frame count to store back |

## Verification
The bench aims at the frame boundary in array-sync mode. There, a design that applied the B step instead of the C step, or failed to reload the array count, would write back a wrong next address or count. It drives negative and mixed-sign steps, so any zero-extension of a step shows up as a far-off address. It also covers zero-sized dimensions, which a careless design would wrap into roughly 65,536 beats. Random back-pressure, and a trigger pulsed mid-slice, expose designs that advance on valid alone or restart while busy.

// File: rtl/dma3d_pkg.sv
package dma3d_pkg;
  typedef enum logic [1:0] {
    GEN_IDLE = 2'd0,
    GEN_RUN  = 2'd1,
    GEN_DONE = 2'd2
  } gen_state_e;
endpackage

// File: rtl/dma3d_seq_ctl.sv
module dma3d_seq_ctl
  import dma3d_pkg::*;
#(
  parameter int unsigned CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          trig_i,
  input  logic [CW-1:0] acnt_i,
  input  logic [CW-1:0] arrays_i,
  input  logic          zero_i,
  input  logic          ready_i,
  output gen_state_e    state_o,
  output logic [CW-1:0] byte_idx_o,
  output logic          valid_o,
  output logic          byte_last_o,
  output logic          slice_last_o,
  output logic          arr_step_o,
  output logic          load_o,
  output logic          done_o
);
  localparam logic [CW-1:0] ONE = CW'(1);

  gen_state_e    state_q;
  logic [CW-1:0] acnt_q, arr_left_q, byte_q;
  logic          fire;

  assign valid_o      = (state_q == GEN_RUN);
  assign fire         = valid_o && ready_i;
  assign byte_last_o  = (byte_q == acnt_q - ONE);
  assign slice_last_o = valid_o && byte_last_o && (arr_left_q == ONE);
  assign arr_step_o   = fire && byte_last_o && (arr_left_q != ONE);
  assign load_o       = (state_q == GEN_IDLE) && trig_i;
  assign done_o       = (state_q == GEN_DONE);
  assign state_o      = state_q;
  assign byte_idx_o   = byte_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= GEN_IDLE;
      acnt_q     <= '0;
      arr_left_q <= '0;
      byte_q     <= '0;
    end else begin
      case (state_q)
        GEN_IDLE: if (trig_i) begin
          acnt_q     <= acnt_i;
          arr_left_q <= arrays_i;
          byte_q     <= '0;
          state_q    <= zero_i ? GEN_DONE : GEN_RUN;
        end
        GEN_RUN: if (fire) begin
          if (byte_last_o) begin
            byte_q <= '0;
            if (arr_left_q == ONE) state_q <= GEN_DONE;
            else arr_left_q <= arr_left_q - ONE;
          end else begin
            byte_q <= byte_q + ONE;
          end
        end
        GEN_DONE: state_q <= GEN_IDLE;
        default:  state_q <= GEN_IDLE;
      endcase
    end
  end

  // R9: the finish flag lasts exactly one cycle
  a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R2: a trigger during a running slice disturbs no counter
  a_r2_busy_trig_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == GEN_RUN && trig_i && !ready_i) |=>
      (state_q == GEN_RUN) && $stable(arr_left_q) && $stable(byte_q));

  // R8: without ready the beat position does not move
  a_r8_idx_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && !ready_i) |=> valid_o && $stable(byte_q));
endmodule

// File: rtl/dma3d_addr_chan.sv
module dma3d_addr_chan #(
  parameter int unsigned AW = 32,
  parameter int unsigned CW = 16,
  parameter int unsigned IW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic [AW-1:0] addr_i,
  input  logic [IW-1:0] bidx_i,
  input  logic [IW-1:0] cidx_i,
  input  logic          arr_step_i,
  input  logic [CW-1:0] byte_idx_i,
  input  logic          use_c_i,
  input  logic          hold_i,
  output logic [AW-1:0] addr_o,
  output logic [AW-1:0] wb_addr_o
);
  localparam int unsigned XW = AW - IW;
  localparam int unsigned ZW = AW - CW;

  logic [AW-1:0] base_q, arr_q, bstep_q, cstep_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q  <= '0;
      arr_q   <= '0;
      bstep_q <= '0;
      cstep_q <= '0;
    end else if (load_i) begin
      base_q  <= addr_i;
      arr_q   <= addr_i;
      bstep_q <= {{XW{bidx_i[IW-1]}}, bidx_i};
      cstep_q <= {{XW{cidx_i[IW-1]}}, cidx_i};
    end else if (arr_step_i) begin
      arr_q <= arr_q + bstep_q;
    end
  end

  assign addr_o = arr_q + {{ZW{1'b0}}, byte_idx_i};

  always_comb begin
    if (hold_i)       wb_addr_o = base_q;
    else if (use_c_i) wb_addr_o = base_q + cstep_q;
    else              wb_addr_o = base_q + bstep_q;
  end

  // R7: the slice start is captured once per trigger and kept
  a_r7_base_kept: assert property (@(posedge clk) disable iff (!rst_n)
    !load_i |=> $stable(base_q));
endmodule

// File: rtl/dma3d_wb_calc.sv
module dma3d_wb_calc #(
  parameter int unsigned CW = 16
) (
  input  logic          ab_i,
  input  logic          zero_i,
  input  logic [CW-1:0] bcnt_i,
  input  logic [CW-1:0] ccnt_i,
  input  logic [CW-1:0] rld_i,
  output logic          use_c_o,
  output logic [CW-1:0] bcnt_o,
  output logic [CW-1:0] ccnt_o,
  output logic          last_frame_o
);
  localparam logic [CW-1:0] ONE = CW'(1);

  logic frame_end;
  assign frame_end = ab_i || (bcnt_i == ONE);
  assign use_c_o   = frame_end;

  always_comb begin
    if (zero_i) begin
      bcnt_o = bcnt_i;
      ccnt_o = '0;
    end else if (ab_i) begin
      bcnt_o = bcnt_i;
      ccnt_o = ccnt_i - ONE;
    end else if (frame_end) begin
      bcnt_o = rld_i;
      ccnt_o = ccnt_i - ONE;
    end else begin
      bcnt_o = bcnt_i - ONE;
      ccnt_o = ccnt_i;
    end
  end

  assign last_frame_o = (ccnt_o == '0);
endmodule

// File: rtl/dma3d_addr_gen.sv
module dma3d_addr_gen
  import dma3d_pkg::*;
#(
  parameter int unsigned AW = 32,
  parameter int unsigned CW = 16,
  parameter int unsigned IW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          trig_i,
  input  logic [AW-1:0] cfg_src_i,
  input  logic [AW-1:0] cfg_dst_i,
  input  logic [CW-1:0] cfg_acnt_i,
  input  logic [CW-1:0] cfg_bcnt_i,
  input  logic [CW-1:0] cfg_ccnt_i,
  input  logic [CW-1:0] cfg_bcnt_rld_i,
  input  logic [IW-1:0] cfg_src_bidx_i,
  input  logic [IW-1:0] cfg_dst_bidx_i,
  input  logic [IW-1:0] cfg_src_cidx_i,
  input  logic [IW-1:0] cfg_dst_cidx_i,
  input  logic          cfg_ab_sync_i,
  output logic          busy_o,
  output logic          addr_valid_o,
  input  logic          addr_ready_i,
  output logic [AW-1:0] addr_src_o,
  output logic [AW-1:0] addr_dst_o,
  output logic          addr_last_o,
  output logic          done_o,
  output logic          eot_o,
  output logic [AW-1:0] wb_src_o,
  output logic [AW-1:0] wb_dst_o,
  output logic [CW-1:0] wb_bcnt_o,
  output logic [CW-1:0] wb_ccnt_o
);
  localparam int unsigned NCH = 2;
  localparam logic [CW-1:0] ONE = CW'(1);

  gen_state_e    state;
  logic [CW-1:0] byte_idx, arrays_live;
  logic          zero_live, byte_last, arr_step, load, done, use_c, last_frame;
  logic          ab_q, zero_q;
  logic [CW-1:0] bcnt_q, ccnt_q, rld_q;

  assign zero_live   = (cfg_acnt_i == '0) || (cfg_bcnt_i == '0) || (cfg_ccnt_i == '0);
  assign arrays_live = cfg_ab_sync_i ? cfg_bcnt_i : ONE;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ab_q   <= 1'b0;
      zero_q <= 1'b0;
      bcnt_q <= '0;
      ccnt_q <= '0;
      rld_q  <= '0;
    end else if (load) begin
      ab_q   <= cfg_ab_sync_i;
      zero_q <= zero_live;
      bcnt_q <= cfg_bcnt_i;
      ccnt_q <= cfg_ccnt_i;
      rld_q  <= cfg_bcnt_rld_i;
    end
  end

  dma3d_seq_ctl #(.CW(CW)) seq_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .trig_i       (trig_i),
    .acnt_i       (cfg_acnt_i),
    .arrays_i     (arrays_live),
    .zero_i       (zero_live),
    .ready_i      (addr_ready_i),
    .state_o      (state),
    .byte_idx_o   (byte_idx),
    .valid_o      (addr_valid_o),
    .byte_last_o  (byte_last),
    .slice_last_o (addr_last_o),
    .arr_step_o   (arr_step),
    .load_o       (load),
    .done_o       (done)
  );

  dma3d_wb_calc #(.CW(CW)) wb_i (
    .ab_i         (ab_q),
    .zero_i       (zero_q),
    .bcnt_i       (bcnt_q),
    .ccnt_i       (ccnt_q),
    .rld_i        (rld_q),
    .use_c_o      (use_c),
    .bcnt_o       (wb_bcnt_o),
    .ccnt_o       (wb_ccnt_o),
    .last_frame_o (last_frame)
  );

  logic [AW-1:0] ch_cfg  [NCH];
  logic [IW-1:0] ch_bidx [NCH];
  logic [IW-1:0] ch_cidx [NCH];
  logic [AW-1:0] ch_addr [NCH];
  logic [AW-1:0] ch_wb   [NCH];

  assign ch_cfg[0]  = cfg_src_i;
  assign ch_cfg[1]  = cfg_dst_i;
  assign ch_bidx[0] = cfg_src_bidx_i;
  assign ch_bidx[1] = cfg_dst_bidx_i;
  assign ch_cidx[0] = cfg_src_cidx_i;
  assign ch_cidx[1] = cfg_dst_cidx_i;

  for (genvar g = 0; g < NCH; g++) begin : g_chan
    dma3d_addr_chan #(.AW(AW), .CW(CW), .IW(IW)) chan_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .load_i     (load),
      .addr_i     (ch_cfg[g]),
      .bidx_i     (ch_bidx[g]),
      .cidx_i     (ch_cidx[g]),
      .arr_step_i (arr_step),
      .byte_idx_i (byte_idx),
      .use_c_i    (use_c),
      .hold_i     (zero_q),
      .addr_o     (ch_addr[g]),
      .wb_addr_o  (ch_wb[g])
    );
  end

  assign addr_src_o = ch_addr[0];
  assign addr_dst_o = ch_addr[1];
  assign wb_src_o   = ch_wb[0];
  assign wb_dst_o   = ch_wb[1];
  assign busy_o     = (state != GEN_IDLE);
  assign done_o     = done;
  assign eot_o      = done && last_frame;

  // R8: back-pressure freezes the whole beat
  a_r8_beat_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_valid_o && !addr_ready_i) |=>
      addr_valid_o && $stable(addr_src_o) && $stable(addr_dst_o) && $stable(addr_last_o));

  // R3: inside an array both addresses climb by one per accepted beat
  a_r3_byte_step: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_valid_o && addr_ready_i && !byte_last) |=>
      (addr_src_o == $past(addr_src_o) + AW'(1)) && (addr_dst_o == $past(addr_dst_o) + AW'(1)));

  // R11: an empty descriptor finishes right after the trigger
  a_r11_empty_finish: assert property (@(posedge clk) disable iff (!rst_n)
    (load && zero_live) |=> done_o && eot_o && !addr_valid_o);

  // R9: finish and stream never overlap; the last beat ends the slice
  a_r9_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_o && addr_valid_o));
  a_r9_last_then_done: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_last_o && addr_ready_i) |=> done_o);

  // R10: end of transfer only rides on a finish pulse
  a_r10_eot_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    eot_o |-> done_o);
endmodule

// File: tb/dma3d_addr_gen_tb_top.sv
module dma3d_addr_gen_tb_top;
  localparam int unsigned AW = 32;
  localparam int unsigned CW = 16;
  localparam int unsigned IW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic          trig_i = 1'b0;
  logic [AW-1:0] cfg_src_i = '0, cfg_dst_i = '0;
  logic [CW-1:0] cfg_acnt_i = '0, cfg_bcnt_i = '0, cfg_ccnt_i = '0, cfg_bcnt_rld_i = '0;
  logic [IW-1:0] cfg_src_bidx_i = '0, cfg_dst_bidx_i = '0, cfg_src_cidx_i = '0, cfg_dst_cidx_i = '0;
  logic          cfg_ab_sync_i = 1'b0;
  logic          addr_ready_i = 1'b0;
  logic          busy_o, addr_valid_o, addr_last_o, done_o, eot_o;
  logic [AW-1:0] addr_src_o, addr_dst_o, wb_src_o, wb_dst_o;
  logic [CW-1:0] wb_bcnt_o, wb_ccnt_o;

  dma3d_addr_gen #(.AW(AW), .CW(CW), .IW(IW)) dut_i (
    .clk(clk), .rst_n(rst_n), .trig_i(trig_i),
    .cfg_src_i(cfg_src_i), .cfg_dst_i(cfg_dst_i),
    .cfg_acnt_i(cfg_acnt_i), .cfg_bcnt_i(cfg_bcnt_i), .cfg_ccnt_i(cfg_ccnt_i),
    .cfg_bcnt_rld_i(cfg_bcnt_rld_i),
    .cfg_src_bidx_i(cfg_src_bidx_i), .cfg_dst_bidx_i(cfg_dst_bidx_i),
    .cfg_src_cidx_i(cfg_src_cidx_i), .cfg_dst_cidx_i(cfg_dst_cidx_i),
    .cfg_ab_sync_i(cfg_ab_sync_i), .busy_o(busy_o),
    .addr_valid_o(addr_valid_o), .addr_ready_i(addr_ready_i),
    .addr_src_o(addr_src_o), .addr_dst_o(addr_dst_o), .addr_last_o(addr_last_o),
    .done_o(done_o), .eot_o(eot_o),
    .wb_src_o(wb_src_o), .wb_dst_o(wb_dst_o), .wb_bcnt_o(wb_bcnt_o), .wb_ccnt_o(wb_ccnt_o)
  );

  int checks = 0;
  int errors = 0;

  // descriptor model
  logic [AW-1:0] m_src, m_dst;
  logic [CW-1:0] m_acnt, m_bcnt, m_ccnt, m_rld;
  logic [IW-1:0] m_sb, m_db, m_sc, m_dc;
  logic          m_ab;
  bit            contig_chk = 0;
  longint        flat_n = 0;
  logic [AW-1:0] flat_base = '0;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [AW-1:0] sx(input logic [IW-1:0] v);
    return {{(AW-IW){v[IW-1]}}, v};
  endfunction

  function automatic logic [AW-1:0] exp_addr(input logic [AW-1:0] base, input logic [IW-1:0] bidx,
                                             input int k, input int j);
    return base + sx(bidx) * AW'(k) + AW'(j);
  endfunction

  task automatic run_slice(input bit inject, output bit got_eot);
    bit zero;
    int arrays, total, n, cyc;
    bit seen_done, prev_stall;
    logic [AW-1:0] ps, pd;
    logic pl;
    logic [AW-1:0] e_src, e_dst;
    logic [CW-1:0] e_b, e_c;
    zero   = (m_acnt == 0) || (m_bcnt == 0) || (m_ccnt == 0);
    arrays = m_ab ? int'(m_bcnt) : 1;
    total  = zero ? 0 : arrays * int'(m_acnt);
    // expected write-back
    if (zero) begin
      e_src = m_src; e_dst = m_dst; e_b = m_bcnt; e_c = '0;
    end else if (m_ab) begin
      e_src = m_src + sx(m_sc); e_dst = m_dst + sx(m_dc); e_b = m_bcnt; e_c = m_ccnt - 1;
    end else if (m_bcnt == 1) begin
      e_src = m_src + sx(m_sc); e_dst = m_dst + sx(m_dc); e_b = m_rld; e_c = m_ccnt - 1;
    end else begin
      e_src = m_src + sx(m_sb); e_dst = m_dst + sx(m_db); e_b = m_bcnt - 1; e_c = m_ccnt;
    end
    @(negedge clk);
    cfg_src_i = m_src; cfg_dst_i = m_dst; cfg_acnt_i = m_acnt; cfg_bcnt_i = m_bcnt;
    cfg_ccnt_i = m_ccnt; cfg_bcnt_rld_i = m_rld; cfg_src_bidx_i = m_sb; cfg_dst_bidx_i = m_db;
    cfg_src_cidx_i = m_sc; cfg_dst_cidx_i = m_dc; cfg_ab_sync_i = m_ab;
    trig_i = 1'b1;
    @(negedge clk);
    trig_i = 1'b0;
    n = 0; cyc = 0; seen_done = 0; prev_stall = 0; ps = '0; pd = '0; pl = 1'b0;
    while (!seen_done && cyc < 5000) begin
      addr_ready_i = ($urandom % 4) != 0;
      if (inject && cyc == 1) begin
        trig_i = 1'b1; cfg_src_i = $urandom; cfg_acnt_i = 16'd7; cfg_ab_sync_i = ~m_ab;
      end else begin
        trig_i = 1'b0;
      end
      if (done_o) begin
        seen_done = 1;
        check(n == total, zero ? "R11" : "R9", "beats before done", n, total);
        check(wb_src_o == e_src, m_ab ? "R7" : (m_bcnt == 1 ? "R6" : "R5"), "wb src", wb_src_o, e_src);
        check(wb_dst_o == e_dst, m_ab ? "R7" : (m_bcnt == 1 ? "R6" : "R5"), "wb dst", wb_dst_o, e_dst);
        check(wb_bcnt_o == e_b, m_ab ? "R7" : (m_bcnt == 1 ? "R6" : "R5"), "wb bcnt", wb_bcnt_o, e_b);
        check(wb_ccnt_o == e_c, zero ? "R11" : "R10", "wb ccnt", wb_ccnt_o, e_c);
        check(eot_o == (e_c == 0), "R10", "eot", eot_o, (e_c == 0));
        check(!addr_valid_o, "R9", "valid in done", addr_valid_o, 0);
      end else begin
        check(!eot_o, "R10", "eot without done", eot_o, 0);
        if (prev_stall)
          check(addr_valid_o && addr_src_o == ps && addr_dst_o == pd && addr_last_o == pl,
                "R8", "stalled beat held", addr_src_o, ps);
        if (addr_valid_o) begin
          check(n < total, zero ? "R11" : "R9", "extra beat", n, total);
          if (addr_ready_i && n < total) begin
            check(addr_src_o == exp_addr(m_src, m_sb, n / int'(m_acnt), n % int'(m_acnt)),
                  (n % int'(m_acnt)) == 0 ? "R4" : "R3", "src addr", addr_src_o,
                  exp_addr(m_src, m_sb, n / int'(m_acnt), n % int'(m_acnt)));
            check(addr_dst_o == exp_addr(m_dst, m_db, n / int'(m_acnt), n % int'(m_acnt)),
                  (n % int'(m_acnt)) == 0 ? "R4" : "R3", "dst addr", addr_dst_o,
                  exp_addr(m_dst, m_db, n / int'(m_acnt), n % int'(m_acnt)));
            check(addr_last_o == (n == total - 1), "R9", "last flag", addr_last_o, (n == total - 1));
            if (contig_chk) begin
              check(addr_src_o == flat_base + AW'(flat_n), "R6", "contiguous src", addr_src_o,
                    flat_base + AW'(flat_n));
              flat_n++;
            end
            n++;
          end
        end
        prev_stall = addr_valid_o && !addr_ready_i;
        ps = addr_src_o; pd = addr_dst_o; pl = addr_last_o;
      end
      @(negedge clk);
      cyc++;
    end
    trig_i = 1'b0;
    check(seen_done, "R9", "done seen", seen_done, 1);
    // the cycle after the pulse: idle, no second slice
    check(!done_o && !busy_o && !addr_valid_o, "R2", "idle after done", {busy_o, done_o, addr_valid_o}, 0);
    m_src = e_src; m_dst = e_dst; m_bcnt = e_b; m_ccnt = e_c;
    got_eot = (e_c == 0);
  endtask

  task automatic run_transfer(input bit inject);
    bit eot;
    int guard = 0;
    eot = 0;
    while (!eot && guard < 64) begin
      run_slice(inject && guard == 0, eot);
      guard++;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0451));
    repeat (3) @(negedge clk);
    check(!busy_o && !addr_valid_o && !done_o && !eot_o, "R1", "reset idle",
          {busy_o, addr_valid_o, done_o, eot_o}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!busy_o && !addr_valid_o && !done_o, "R1", "idle after release", busy_o, 0);

    // 12 contiguous bytes, array sync (R5, R6)
    m_src = 32'h100; m_dst = 32'h800; m_acnt = 2; m_bcnt = 2; m_ccnt = 3; m_rld = 2;
    m_sb = 2; m_db = 2; m_sc = 2; m_dc = 2; m_ab = 0;
    contig_chk = 1; flat_n = 0; flat_base = 32'h100;
    run_transfer(0);
    check(flat_n == 12, "R6", "contiguous byte count", flat_n, 12);

    // same bytes, frame sync (R7)
    m_src = 32'h100; m_dst = 32'h800; m_acnt = 2; m_bcnt = 2; m_ccnt = 3; m_rld = 2;
    m_sb = 2; m_db = 2; m_sc = 4; m_dc = 4; m_ab = 1;
    flat_n = 0;
    run_transfer(0);
    check(flat_n == 12, "R7", "contiguous byte count", flat_n, 12);
    contig_chk = 0;

    // empty dimensions (R11)
    for (int z = 0; z < 3; z++) begin
      m_src = 32'h4000; m_dst = 32'h5000; m_acnt = 3; m_bcnt = 2; m_ccnt = 2; m_rld = 2;
      m_sb = 16'hfff0; m_db = 5; m_sc = 1; m_dc = 1; m_ab = z[0];
      if (z == 0) m_acnt = 0;
      if (z == 1) m_bcnt = 0;
      if (z == 2) m_ccnt = 0;
      run_transfer(0);
    end

    // trigger pulsed while busy (R2)
    m_src = 32'h2000; m_dst = 32'h3000; m_acnt = 4; m_bcnt = 3; m_ccnt = 2; m_rld = 3;
    m_sb = 16'hffe0; m_db = 8; m_sc = 16'h0100; m_dc = 16'hff00; m_ab = 1;
    run_transfer(1);

    // constrained random descriptors with signed steps
    for (int t = 0; t < 40; t++) begin
      m_src  = $urandom; m_dst = $urandom;
      m_acnt = CW'(1 + $urandom % 5);
      m_rld  = CW'(1 + $urandom % 4);
      m_bcnt = ($urandom % 3 == 0) ? CW'(1 + $urandom % 4) : m_rld;
      m_ccnt = CW'(1 + $urandom % 3);
      m_sb = IW'($urandom % 64) - IW'(32);
      m_db = IW'($urandom % 64) - IW'(32);
      m_sc = IW'($urandom % 512) - IW'(256);
      m_dc = IW'($urandom % 512) - IW'(256);
      m_ab = $urandom % 2;
      run_transfer(t % 7 == 3);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule